// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Controller

This block serves a long sequential read stream out of two word-wide storage banks. One bank holds the even word addresses and the other holds the odd ones. A start cycle latches a word address. From that point each read strobe presents the next word in address order. The controller alternates between the banks, so each bank only has to supply every second word. Each bank has its own word counter. The lowest address bit at the start cycle decides how the two counters are seeded and which bank supplies the first word. Each counter then advances only after its own bank has been read.

A burst has no length limit. When a counter runs past the top of its bank, it wraps to word zero. Raising chip select puts the block in standby: the output enable drops and the data bus reads zero. Counter and bank-select state is held through standby. Lowering chip select again, without a start, continues the burst from the word where it stopped. A new start cycle may interrupt a burst at any point. All strobes are sampled on the system clock, and the bank contents are written through a simple load port. The bank depth is a parameter: the default keeps elaboration small, and a full-size instance sets `BANK_AW` to 15.

Top module: `ilv_burst_rd`

## Requirements
- R1: After reset, `oe_o` is 0, `dout_o` is 0, and the even bank is marked as the next bank.
- R2: A start cycle is a clock edge with `ale_i`=1 and `cs_n_i`=0. If `addr_i[0]`=0 at that edge, `dout_o` shows even word A one cycle later, where A=`addr_i[BANK_AW:1]`. The following steps give odd A, even A+1, odd A+1, and so on.
- R3: If `addr_i[0]`=1 at the start edge, `dout_o` shows odd word A one cycle later. The following steps give even A+1, odd A+1, even A+2, and so on.
- R4: A step is a clock edge with `ale_i`=0 and `cs_n_i`=0 where `rd_i` is 1 and was 0 at the previous edge. Each step presents the next word one cycle later. Holding `rd_i` high or low presents no new word.
- R5: A bank counter that passes word 2^BANK_AW-1 wraps to word 0, and the burst continues.
- R6: One cycle after an edge with `cs_n_i`=1, `oe_o` is 0 and `dout_o` is 0. Read strobe edges seen during standby do not advance the burst.
- R7: If `cs_n_i` returns to 0 with `ale_i` low, `oe_o` is 1 one cycle later. `dout_o` again shows the last presented word, and the next step continues the sequence from where it stopped.
- R8: A start cycle during a burst discards the old position and reseeds both counters as in R2 and R3.
- R9: At a start edge, a rising `rd_i` does not produce an extra step.
- R10: A write on the load port with `load_we_i`=1 stores `load_data_i` in the bank chosen by `load_addr_i[0]` (0 = even, 1 = odd) at word `load_addr_i[BANK_AW:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch enable; high with chip select low starts a burst |
| cs_n_i | input | 1 | Active-low chip select; high means standby |
| rd_i | input | 1 | Read strobe; each rising edge requests the next word |
| addr_i | input | BANK_AW+1 | Start address; bit 0 picks the first bank |
| load_we_i | input | 1 | Load port write enable |
| load_addr_i | input | BANK_AW+1 | Load address; bit 0 picks the bank, upper bits the word |
| load_data_i | input | DATA_W | Load port write data |
| dout_o | output | DATA_W | Read data, zero while the output is disabled |
| oe_o | output | 1 | Output enable; low means the bus is floated |

## Verification
The assertions assume that every strobe and address input is a known value at each clock edge and is synchronous to `clk`. They also assume that the load port is not writing while a burst reads the same word. The bench writes the banks only while chip select is high, before any burst starts. It changes strobes and addresses only on the falling clock edge. The random phase draws start cycles, standby periods and read strobe levels at fixed rates, so bursts are often interrupted at arbitrary points.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;
endpackage

// File: rtl/ilv_strobe_dec.sv
module ilv_strobe_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic ale_i,
  input  logic cs_n_i,
  input  logic rd_i,
  output logic start_o,
  output logic step_o
);
  logic rd_q;
  logic rd_d;

  always_comb begin
    rd_d    = rd_i;
    start_o = ale_i & ~cs_n_i;
    step_o  = ~ale_i & ~cs_n_i & rd_i & ~rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_d;
  end
endmodule

// File: rtl/ilv_word_ctr.sv
module ilv_word_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] cnt_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] cnt_q;
  logic [AW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | inc_i;
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ilv_bank_ram.sv
module ilv_bank_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/ilv_burst_rd.sv
module ilv_burst_rd
  import ilv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BANK_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ale_i,
  input  logic               cs_n_i,
  input  logic               rd_i,
  input  logic [BANK_AW:0]   addr_i,
  input  logic               load_we_i,
  input  logic [BANK_AW:0]   load_addr_i,
  input  logic [DATA_W-1:0]  load_data_i,
  output logic [DATA_W-1:0]  dout_o,
  output logic               oe_o
);
  localparam int NBANK = 2;
  localparam logic [BANK_AW-1:0] ONE = BANK_AW'(1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // strobe decode
  logic start;
  logic step;

  ilv_strobe_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ale_i   (ale_i),
    .cs_n_i  (cs_n_i),
    .rd_i    (rd_i),
    .start_o (start),
    .step_o  (step)
  );

  // seed values for a start cycle
  logic [BANK_AW-1:0] seed;
  logic [BANK_AW-1:0] seed_inc;
  logic               a0;

  assign seed     = addr_i[BANK_AW:1];
  assign a0       = addr_i[0];
  assign seed_inc = seed + ONE;

  bank_e sel_q;
  bank_e sel_d;
  logic  sel_odd;

  assign sel_odd = (sel_q == BANK_ODD);

  logic [NBANK-1:0][BANK_AW-1:0] ctr;
  logic [NBANK-1:0][BANK_AW-1:0] ctr_seed;
  logic [NBANK-1:0][DATA_W-1:0]  rdata;

  // even bank always reseeds one past the start word; odd bank by a0
  assign ctr_seed[0] = seed_inc;
  assign ctr_seed[1] = a0 ? seed_inc : seed;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam bank_e THIS_BANK = bank_e'(b);
    logic               inc;
    logic               we;
    logic [BANK_AW-1:0] raddr;

    assign inc   = step & (sel_q == THIS_BANK);
    assign we    = load_we_i & (load_addr_i[0] == THIS_BANK);
    assign raddr = start ? seed : ctr[b];

    ilv_word_ctr #(.AW(BANK_AW)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .load_i     (start),
      .load_val_i (ctr_seed[b]),
      .inc_i      (inc),
      .cnt_o      (ctr[b])
    );

    ilv_bank_ram #(.AW(BANK_AW), .DW(DATA_W)) u_ram (
      .clk     (clk),
      .we_i    (we),
      .waddr_i (load_addr_i[BANK_AW:1]),
      .wdata_i (load_data_i),
      .raddr_i (raddr),
      .rdata_o (rdata[b])
    );
  end

  // output datapath
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] dout_d;
  logic              dout_en;
  logic              oe_q;
  logic              oe_d;

  always_comb begin
    sel_d   = sel_q;
    dout_d  = dout_q;
    dout_en = start | step;
    oe_d    = ~cs_n_i;
    if (start) begin
      dout_d = rdata[a0];
      sel_d  = a0 ? BANK_EVEN : BANK_ODD;
    end else if (step) begin
      dout_d = rdata[sel_odd];
      sel_d  = sel_odd ? BANK_EVEN : BANK_ODD;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q  <= BANK_EVEN;
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= oe_d;
      if (dout_en) begin
        sel_q  <= sel_d;
        dout_q <= dout_d;
      end
    end
  end

  assign dout_o = oe_q ? dout_q : '0;
  assign oe_o   = oe_q;
endmodule

// File: rtl/ilv_burst_rd_chk.sv
module ilv_burst_rd_chk
  import ilv_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BANK_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ale_i,
  input logic               cs_n_i,
  input logic [BANK_AW:0]   addr_i,
  input logic               start,
  input logic               step,
  input bank_e              sel_q,
  input logic [BANK_AW-1:0] ctr_even,
  input logic [BANK_AW-1:0] ctr_odd,
  input logic [DATA_W-1:0]  dout_q,
  input logic [DATA_W-1:0]  dout_o,
  input logic               oe_o
);
  // R6
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> (!oe_o && dout_o == '0));

  // R6
  float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> dout_o == '0);

  // R7
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |=> ($stable(sel_q) && $stable(ctr_even) && $stable(ctr_odd)));

  // R7
  select_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !ale_i) |=> oe_o);

  // R2
  start_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sel_q == bank_e'(~$past(addr_i[0]))));

  // R2
  even_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ctr_even == BANK_AW'($past(addr_i[BANK_AW:1]) + BANK_AW'(1))));

  // R3
  odd_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ctr_odd == BANK_AW'($past(addr_i[BANK_AW:1]) + BANK_AW'($past(addr_i[0])))));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(dout_q));

  // R4
  step_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sel_q != $past(sel_q)));

  // R9
  ale_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |-> !step);
endmodule

bind ilv_burst_rd ilv_burst_rd_chk #(.DATA_W(DATA_W), .BANK_AW(BANK_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ale_i    (ale_i),
  .cs_n_i   (cs_n_i),
  .addr_i   (addr_i),
  .start    (start),
  .step     (step),
  .sel_q    (sel_q),
  .ctr_even (ctr[0]),
  .ctr_odd  (ctr[1]),
  .dout_q   (dout_q),
  .dout_o   (dout_o),
  .oe_o     (oe_o)
);

// File: tb/ilv_burst_rd_tb_top.sv
`timescale 1ns/1ps
module ilv_burst_rd_tb_top;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ale, cs_n, rd;
  logic [AW:0]   addr;
  logic          load_we;
  logic [AW:0]   load_addr;
  logic [DW-1:0] load_data;
  logic [DW-1:0] dout_o;
  logic          oe_o;

  always #2.5 clk = ~clk;

  ilv_burst_rd #(.DATA_W(DW), .BANK_AW(AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ale_i       (ale),
    .cs_n_i      (cs_n),
    .rd_i        (rd),
    .addr_i      (addr),
    .load_we_i   (load_we),
    .load_addr_i (load_addr),
    .load_data_i (load_data),
    .dout_o      (dout_o),
    .oe_o        (oe_o)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done   = 1'b0;

  logic [DW-1:0] mem_e [DEPTH];
  logic [DW-1:0] mem_o [DEPTH];

  // reference state
  int unsigned   m_ev, m_od;
  bit            m_sel;
  bit            m_rdp;
  bit            m_oe;
  logic [DW-1:0] m_word;

  function automatic logic [DW-1:0] bank_word(bit odd, int unsigned idx);
    return odd ? mem_o[idx % DEPTH] : mem_e[idx % DEPTH];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(string req);
    int unsigned a;
    bit          a0;
    @(posedge clk);
    if (!cs_n && ale) begin
      a      = int'(addr[AW:1]);
      a0     = addr[0];
      m_word = bank_word(a0, a);
      m_ev   = (a + 1) % DEPTH;
      m_od   = (a + a0) % DEPTH;
      m_sel  = !a0;
    end else if (!cs_n && !ale && rd && !m_rdp) begin
      if (m_sel) begin
        m_word = bank_word(1'b1, m_od);
        m_od   = (m_od + 1) % DEPTH;
      end else begin
        m_word = bank_word(1'b0, m_ev);
        m_ev   = (m_ev + 1) % DEPTH;
      end
      m_sel = !m_sel;
    end
    m_rdp = rd;
    m_oe  = !cs_n;
    @(negedge clk);
    chk((oe_o == m_oe) && (dout_o == (m_oe ? m_word : '0)), req,
        {15'd0, oe_o, dout_o}, {15'd0, m_oe, (m_oe ? m_word : 16'h0)});
  endtask

  task automatic drive(bit a_le, bit c_n, bit r, logic [AW:0] ad, string req);
    ale = a_le; cs_n = c_n; rd = r; addr = ad;
    tick(req);
  endtask

  task automatic pulses(int n, string req);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b0, 1'b1, addr, req);
      drive(1'b0, 1'b0, 1'b0, addr, req);
    end
  endtask

  task automatic start_at(int unsigned w, bit lo, string req);
    drive(1'b1, 1'b0, 1'b0, {w[AW-1:0], lo}, req);
    drive(1'b0, 1'b0, 1'b0, {w[AW-1:0], lo}, req);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; ale = 1'b0; cs_n = 1'b1; rd = 1'b0; addr = '0;
    load_we = 1'b0; load_addr = '0; load_data = '0;
    m_ev = 0; m_od = 0; m_sel = 1'b0; m_rdp = 1'b0; m_oe = 1'b0; m_word = '0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(oe_o == 1'b0 && dout_o == '0, "R1", {15'd0, oe_o, dout_o}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick("R1");

    // R10: fill both banks through the load port, bit 0 picks the bank
    for (int i = 0; i < 2 * DEPTH; i++) begin
      load_we   = 1'b1;
      load_addr = (AW + 1)'(i);
      load_data = DW'($urandom);
      if (i[0]) mem_o[i >> 1] = load_data;
      else      mem_e[i >> 1] = load_data;
      tick("R10");
    end
    load_we = 1'b0;
    tick("R10");

    // R2: even-first burst
    start_at(5, 1'b0, "R2");
    pulses(6, "R2");
    // R4: strobe held high then low gives one word only
    drive(1'b0, 1'b0, 1'b1, addr, "R4");
    drive(1'b0, 1'b0, 1'b1, addr, "R4");
    drive(1'b0, 1'b0, 1'b1, addr, "R4");
    drive(1'b0, 1'b0, 1'b0, addr, "R4");
    drive(1'b0, 1'b0, 1'b0, addr, "R4");

    // R3: odd-first burst
    start_at(7, 1'b1, "R3");
    pulses(6, "R3");

    // R5: wrap from the top word in both seedings
    start_at(DEPTH - 1, 1'b1, "R5");
    pulses(5, "R5");
    start_at(DEPTH - 1, 1'b0, "R5");
    pulses(5, "R5");

    // R6: standby floats outputs and ignores strobes
    start_at(2, 1'b0, "R6");
    pulses(3, "R6");
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1, 1'b1, addr, "R6");
      drive(1'b0, 1'b1, 1'b0, addr, "R6");
    end
    // R7: resume where the burst stopped
    drive(1'b0, 1'b0, 1'b0, addr, "R7");
    pulses(4, "R7");

    // R8: restart mid-burst
    start_at(9, 1'b1, "R8");
    pulses(2, "R8");
    start_at(3, 1'b0, "R8");
    pulses(3, "R8");

    // R9: rising strobe coincides with a start
    drive(1'b1, 1'b0, 1'b1, {4'd11, 1'b1}, "R9");
    drive(1'b0, 1'b0, 1'b1, {4'd11, 1'b1}, "R9");
    drive(1'b0, 1'b0, 1'b0, {4'd11, 1'b1}, "R9");
    pulses(2, "R9");

    // random mix of starts, standby and strobes
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 12) == 0, ($urandom % 10) == 0, $urandom % 2,
            (AW + 1)'($urandom), "R7");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule